// File: doc/BRIEF.md
# Dual Down-Counting Watchdog with Divided Fallback Tick

The block holds two independent watchdog counters behind one 32-bit control and status word. Both counters step down by one on a common low-rate tick of nominally 32768 Hz. By default that tick is a rising edge on a slow external clock input. The edge is resynchronised into the system clock domain and detected there. Software can switch once, and for good, to a fallback tick made by dividing the system reference clock by a programmable factor. After the switch, only a reset returns the block to the external input.

Each timer has its own operating mode, its own limit width K and its own interrupt flag. A timer reaches its limit when the K lowest bits of its counter are all zero right after a decrement. In interrupt mode, reaching the limit latches the flag, and the flag drives an interrupt output. In reset mode, reaching the limit gives a one-cycle reset-request pulse. Free-running mode counts but takes no action, and the disabled mode freezes the counter. Every accepted write reloads both counters with all ones. This lets software service the watchdog by rewriting the word. A lock input blocks all writes.

Top module: `twin_wdog`

## Requirements
- R1: After reset the word reads 0x0001_0303. That is: fallback select 0, divider 1, both limit widths 0, both flags 0 and both modes 3. Both interrupt outputs and the reset request are low.
- R2: Read layout of the word:
  - bit 31: fallback select
  - bits 30:16: divider N
  - bits 15:11: K of timer 1
  - bit 10: flag of timer 1
  - bits 9:8: mode of timer 1
  - bits 7:3: K of timer 0
  - bit 2: flag of timer 0
  - bits 1:0: mode of timer 0
- R3: While the lock input is high, a write changes no field and does not reload the counters.
- R4: Writing 1 to bit 31 sets the fallback select. Later writes of 0 leave it set, and only the reset input clears it.
- R5: Bits 30:16 take the written value only while bit 31 reads 0, including the write that sets bit 31. Once bit 31 is 1, they are frozen.
- R6: The tick source depends on bit 31.
  - With bit 31 at 1, one tick occurs every N+1 system clocks.
  - With bit 31 at 0, each rising edge of the slow input gives exactly one tick, after a fixed synchroniser delay.
- R7: Modes 0, 1 and 2 decrement the counter by one per tick. Mode 3 holds it and produces no events. An accepted write reloads both counters with all ones, and no event occurs on that clock.
- R8: A limit event occurs when the K low counter bits are zero after a decrement. With K = 0 every tick is an event.
- R9: In mode 1 (interrupt) a limit event sets the timer's flag, which drives its interrupt output. Writing 1 to the flag bit clears it, and writing 0 leaves it.
- R10: In mode 2 (reset) a limit event raises the reset-request output for exactly one clock, in the cycle after the tick. Modes 0 and 3 never raise it.
- R11: The two timers use separate modes, limit widths, counters and flags, and an event on one does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst_n | input | 1 | Asynchronous active-low pin/power-on reset |
| lf_clk_i | input | 1 | External slow clock, asynchronous to clk |
| wr_en | input | 1 | Write strobe for the control word |
| wr_lock | input | 1 | Write protect; blocks writes while high |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control/status word |
| irq_o | output | 2 | Per-timer interrupt request (level, flag value) |
| rst_req_o | output | 1 | One-cycle reset request from either timer |

## Verification
The properties assume the slow input toggles no faster than every other system clock. They also assume a nonzero divider whenever the fallback tick is in use, so that two ticks never fall on adjacent clocks. The stimulus holds the slow input high and low for three clocks each, and programs divider values of 1 and 3. It writes a divider of 0 only while the external tick is selected. A divide-by-zero setting is never selected as the tick source.

// File: rtl/twdg_pkg.sv
package twdg_pkg;
   localparam int KW    = 5;
   localparam int DIVW  = 15;
   localparam int NTMR  = 2;

   typedef enum logic [1:0] {
      WM_FREE = 2'd0,
      WM_IRQ  = 2'd1,
      WM_RST  = 2'd2,
      WM_OFF  = 2'd3
   } wmode_e;

   typedef struct packed {
      logic [KW-1:0] kbits;
      logic          flag;
      wmode_e        mode;
   } tmr_field_t;

   typedef struct packed {
      logic                  bk_sel;
      logic [DIVW-1:0]       bk_div;
      tmr_field_t [NTMR-1:0] tmr;
   } ctl_word_t;
endpackage

// File: rtl/twdg_tick_src.sv
module twdg_tick_src #(
   parameter int SYNC_STAGES = 2,
   parameter int DIVW        = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lf_clk_i,
   input  logic            use_backup,
   input  logic [DIVW-1:0] div_val,
   output logic            tick
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   seen_q;
   logic                   ext_tick;
   logic [DIVW-1:0]        div_q;
   logic                   div_hit;

   // synchroniser chain, one flop per stage
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= lf_clk_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= sync_q[SYNC_STAGES-1];
   end

   assign ext_tick = sync_q[SYNC_STAGES-1] & ~seen_q;

   // fallback divider: period of div_val+1 clocks
   assign div_hit = (div_q == div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           div_q <= '0;
      else if (!use_backup) div_q <= '0;
      else if (div_hit)     div_q <= '0;
      else                  div_q <= div_q + 1'b1;
   end

   assign tick = use_backup ? div_hit : ext_tick;
endmodule

// File: rtl/twdg_timer.sv
module twdg_timer
   import twdg_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          reload,
   input  wmode_e        mode,
   input  logic [KW-1:0] kbits,
   output logic          hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;
   logic [CNT_W-1:0] lim_mask;
   logic             run;

   assign run      = tick && (mode != WM_OFF) && !reload;
   assign cnt_dec  = cnt_q - 1'b1;
   assign lim_mask = ~({CNT_W{1'b1}} << kbits);
   assign hit      = run && ((cnt_dec & lim_mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '1;
      else if (reload) cnt_q <= '1;
      else if (run)    cnt_q <= cnt_dec;
   end
endmodule

// File: rtl/twdg_regs.sv
module twdg_regs
   import twdg_pkg::*;
#(
   parameter int DIV_RST = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            wr_lock,
   input  logic [31:0]     wr_data,
   input  logic [NTMR-1:0] hit,
   output ctl_word_t       ctl,
   output logic            reload
);
   ctl_word_t ctl_q;
   ctl_word_t wd;
   logic      wr_ok;

   assign wd     = ctl_word_t'(wr_data);
   assign wr_ok  = wr_en & ~wr_lock;
   assign reload = wr_ok;
   assign ctl    = ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q.bk_sel <= 1'b0;
         ctl_q.bk_div <= DIVW'(DIV_RST);
         for (int i = 0; i < NTMR; i++) begin
            ctl_q.tmr[i].kbits <= '0;
            ctl_q.tmr[i].flag  <= 1'b0;
            ctl_q.tmr[i].mode  <= WM_OFF;
         end
      end else begin
         if (wr_ok) begin
            ctl_q.bk_sel <= ctl_q.bk_sel | wd.bk_sel;
            if (!ctl_q.bk_sel) ctl_q.bk_div <= wd.bk_div;
         end
         for (int i = 0; i < NTMR; i++) begin
            if (wr_ok) begin
               ctl_q.tmr[i].kbits <= wd.tmr[i].kbits;
               ctl_q.tmr[i].mode  <= wd.tmr[i].mode;
               ctl_q.tmr[i].flag  <= ctl_q.tmr[i].flag & ~wd.tmr[i].flag;
            end else if (hit[i] && ctl_q.tmr[i].mode == WM_IRQ) begin
               ctl_q.tmr[i].flag  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/twin_wdog.sv
module twin_wdog
   import twdg_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_RST     = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        lf_clk_i,
   input  logic        wr_en,
   input  logic        wr_lock,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic [1:0]  irq_o,
   output logic        rst_req_o
);
   localparam int KMAX = (1 << KW) - 1;

   if (CNT_W < KMAX) begin : g_bad_cnt
      $error("CNT_W must cover the widest limit field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIVW)) begin : g_bad_div
      $error("DIV_RST does not fit the divider field");
   end

   ctl_word_t       ctl;
   logic            reload;
   logic            tick;
   logic [NTMR-1:0] hit;
   logic [NTMR-1:0] rst_hit;
   logic            rst_req_q;

   twdg_regs #(.DIV_RST(DIV_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_lock (wr_lock),
      .wr_data (wr_data),
      .hit     (hit),
      .ctl     (ctl),
      .reload  (reload)
   );

   twdg_tick_src #(.SYNC_STAGES(SYNC_STAGES), .DIVW(DIVW)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .lf_clk_i   (lf_clk_i),
      .use_backup (ctl.bk_sel),
      .div_val    (ctl.bk_div),
      .tick       (tick)
   );

   for (genvar t = 0; t < NTMR; t++) begin : g_tmr
      twdg_timer #(.CNT_W(CNT_W)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick),
         .reload (reload),
         .mode   (ctl.tmr[t].mode),
         .kbits  (ctl.tmr[t].kbits),
         .hit    (hit[t])
      );
      assign rst_hit[t] = hit[t] && (ctl.tmr[t].mode == WM_RST);
      assign irq_o[t]   = ctl.tmr[t].flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= |rst_hit;
   end

   assign rst_req_o = rst_req_q;
   assign rd_data   = ctl;
endmodule

// File: rtl/twdg_chk.sv
module twdg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_lock,
   input logic        clr0,
   input logic        clr1,
   input logic [31:0] rd_data,
   input logic [1:0]  irq_o,
   input logic        rst_req_o
);
   assert_sel_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31] |=> rd_data[31]);

   assert_div_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[31] |=> $stable(rd_data[30:16]));

   assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_lock) |=> $stable({rd_data[31:11], rd_data[9:3], rd_data[1:0]}));

   assert_irq0_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[0]) |-> rd_data[1:0] == 2'd1);

   assert_irq1_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[1]) |-> rd_data[9:8] == 2'd1);

   assert_flag0_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_lock && clr0) |=> !irq_o[0]);

   assert_flag1_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_lock && clr1) |=> !irq_o[1]);

   assert_rst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req_o && rd_data[30:16] != 15'd0) |=> !rst_req_o);

   assert_rst_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> $past(rd_data[1:0] == 2'd2 || rd_data[9:8] == 2'd2));
endmodule

bind twin_wdog twdg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_lock   (wr_lock),
   .clr0      (wr_data[2]),
   .clr1      (wr_data[10]),
   .rd_data   (rd_data),
   .irq_o     (irq_o),
   .rst_req_o (rst_req_o)
);

// File: tb/twin_wdog_test.sv
`timescale 1ns/1ps
module twin_wdog_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lf_clk = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_lock = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  irq_o;
   logic        rst_req_o;

   int n_chk = 0;
   int n_err = 0;
   bit fin = 1'b0;
   bit lf_run = 1'b0;
   int lf_ph = 0;

   twin_wdog uut (
      .clk(clk), .rst_n(rst_n), .lf_clk_i(lf_clk), .wr_en(wr_en), .wr_lock(wr_lock),
      .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .rst_req_o(rst_req_o)
   );

   always #2.5 clk = ~clk;

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] mk(bit s, int d, int k1, int m1, bit f1, int k0, int m0, bit f0);
      return {s, d[14:0], k1[4:0], f1, m1[1:0], k0[4:0], f0, m0[1:0]};
   endfunction

   // slow clock: three system clocks high, three low
   always @(negedge clk) begin
      if (lf_run) begin
         lf_ph++;
         if (lf_ph == 3) begin
            lf_ph = 0;
            lf_clk <= ~lf_clk;
         end
      end
   end

   // behavioural reference model
   logic [31:0] m_cnt [2];
   int          m_mode [2];
   int          m_k [2];
   bit          m_irq [2];
   bit          m_sel;
   int          m_div;
   int          m_dc;
   bit [2:0]    m_h;
   bit          m_rst;
   logic [31:0] m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin
            m_cnt[i] = '1; m_mode[i] = 3; m_k[i] = 0; m_irq[i] = 1'b0;
         end
         m_sel = 1'b0; m_div = 1; m_dc = 0; m_h = '0; m_rst = 1'b0;
      end else begin
         bit tk, wok, rs, ev;
         logic [31:0] nc, msk;
         tk  = m_sel ? (m_dc == m_div) : (m_h[1] && !m_h[2]);
         wok = wr_en && !wr_lock;
         rs  = 1'b0;
         for (int i = 0; i < 2; i++) begin
            ev = 1'b0;
            if (wok) m_cnt[i] = '1;
            else if (tk && m_mode[i] != 3) begin
               nc = m_cnt[i] - 1;
               m_cnt[i] = nc;
               msk = (32'd1 << m_k[i]) - 1;
               ev = ((nc & msk) == 0);
            end
            if (wok) m_irq[i] = m_irq[i] && !wr_data[8*i+2];
            else if (ev && m_mode[i] == 1) m_irq[i] = 1'b1;
            if (ev && m_mode[i] == 2) rs = 1'b1;
         end
         m_rst = rs;
         if (m_sel) m_dc = (m_dc == m_div) ? 0 : m_dc + 1;
         else       m_dc = 0;
         if (wok) begin
            for (int i = 0; i < 2; i++) begin
               m_mode[i] = int'(wr_data[8*i +: 2]);
               m_k[i]    = int'(wr_data[8*i+3 +: 5]);
            end
            if (!m_sel) m_div = int'(wr_data[30:16]);
            m_sel = m_sel | wr_data[31];
         end
         m_h = {m_h[1:0], lf_clk};
      end
   end

   assign m_rd = mk(m_sel, m_div, m_k[1], m_mode[1], m_irq[1], m_k[0], m_mode[0], m_irq[0]);

   // clock-by-clock comparison
   always @(negedge clk) begin
      if (!fin) begin
         check(rd_data == m_rd, "R2 word", rd_data, m_rd);
         check(irq_o == {m_irq[1], m_irq[0]}, "R9 irq", {30'd0, irq_o}, {30'd0, m_irq[1], m_irq[0]});
         check(rst_req_o == m_rst, "R10 rst_req", {31'd0, rst_req_o}, {31'd0, m_rst});
      end
   end

   task automatic wr(logic [31:0] d, bit lock);
      @(negedge clk);
      wr_en <= 1'b1; wr_data <= d; wr_lock <= lock;
      @(negedge clk);
      wr_en <= 1'b0; wr_lock <= 1'b0;
   endtask

   task automatic count_rst(int n, output int cnt);
      cnt = 0;
      repeat (n) begin
         @(negedge clk); #1;
         if (rst_req_o) cnt++;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int c;
      logic [31:0] snap;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(rd_data == 32'h0001_0303, "R1 reset word", rd_data, 32'h0001_0303);
      check(irq_o == 2'b00 && !rst_req_o, "R1 outputs", {29'd0, irq_o, rst_req_o}, 32'd0);

      // R2 field layout
      wr(mk(0, 15'h1234, 21, 0, 0, 9, 3, 0), 0);
      #1;
      check(rd_data == 32'h1234_A84B, "R2 layout", rd_data, 32'h1234_A84B);

      // R9 interrupt set and clear
      lf_run = 1'b1;
      wr(mk(0, 1, 0, 3, 0, 2, 1, 0), 0);
      repeat (60) @(negedge clk);
      #1;
      check(irq_o[0] == 1'b1, "R9 flag set", {31'd0, irq_o[0]}, 32'd1);
      check(irq_o[1] == 1'b0, "R7 mode3 quiet", {31'd0, irq_o[1]}, 32'd0);
      wr(mk(0, 1, 0, 3, 0, 31, 1, 0), 0);
      #1;
      check(irq_o[0] == 1'b1, "R9 write 0 keeps", {31'd0, irq_o[0]}, 32'd1);
      wr(mk(0, 1, 0, 3, 0, 31, 1, 1), 0);
      #1;
      check(irq_o[0] == 1'b0, "R9 write 1 clears", {31'd0, irq_o[0]}, 32'd0);

      // R3 locked write
      snap = rd_data;
      wr(mk(1, 5, 4, 2, 0, 4, 2, 0), 1);
      #1;
      check(rd_data == snap, "R3 locked write", rd_data, snap);

      // R6 external tick, K=0
      wr(mk(0, 0, 0, 3, 0, 0, 2, 0), 0);
      count_rst(60, c);
      check(c == 10, "R6 external tick rate", c, 10);

      // R8 limit widths
      wr(mk(0, 1, 0, 3, 0, 1, 2, 0), 0);
      count_rst(120, c);
      check(c == 10, "R8 K=1", c, 10);
      wr(mk(0, 1, 0, 3, 0, 3, 2, 0), 0);
      count_rst(288, c);
      check(c == 6, "R8 K=3", c, 6);

      // R7 disabled mode holds
      wr(mk(0, 1, 0, 3, 0, 0, 3, 0), 0);
      count_rst(100, c);
      check(c == 0, "R7 both disabled", c, 0);
      check(irq_o == 2'b00, "R7 no flags", {30'd0, irq_o}, 32'd0);

      // R11 independent timers
      wr(mk(0, 1, 1, 1, 0, 0, 2, 0), 0);
      count_rst(60, c);
      check(c == 10, "R11 timer0 pulses", c, 10);
      check(irq_o == 2'b10, "R11 only timer1 flag", {30'd0, irq_o}, 32'd2);

      // R5/R6 fallback tick, divider set in the same write
      wr(mk(1, 3, 0, 3, 0, 0, 2, 0), 0);
      #1;
      check(rd_data[31] == 1'b1 && rd_data[30:16] == 15'd3, "R5 divider taken with select",
            {16'd0, rd_data[31:16]}, {16'd0, 1'b1, 15'd3});
      count_rst(80, c);
      check(c == 20, "R6 divided tick rate", c, 20);

      // R4/R5 sticky select and frozen divider
      wr(mk(0, 7, 0, 3, 0, 0, 2, 0), 0);
      #1;
      check(rd_data[31] == 1'b1, "R4 select sticky", {31'd0, rd_data[31]}, 32'd1);
      check(rd_data[30:16] == 15'd3, "R5 divider frozen", {17'd0, rd_data[30:16]}, 32'd3);
      wr(mk(0, 7, 0, 3, 0, 1, 2, 0), 0);
      count_rst(80, c);
      check(c == 10, "R8 K=1 on divided tick", c, 10);

      // R4 reset clears select
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(rd_data == 32'h0001_0303, "R4 reset clears select", rd_data, 32'h0001_0303);
      repeat (4) @(negedge clk);
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule